// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

The block is a weekly alarm for a real-time clock. Software programs three alarm bytes: minutes, hours and day of week. The top bit of each byte is a "don't care" mask. Once per second, at the rollover of the hundredths counter, the block compares the pending time against the unmasked alarm fields. On a match at a minute boundary it raises an alarm flag. The choice of mask bits sets the alarm rate: every minute, hourly, daily or weekly.

The clock counters are kept outside the block. They arrive as inputs that carry the incremented time, which becomes visible when hundredths roll from 99 to 00. The flag drives an interrupt that can be suppressed, and it is steered to one of two outputs. In level mode the interrupt holds until software reads or writes any alarm byte. In pulse mode it lasts a fixed number of clock cycles. An access to any alarm byte clears a pending event in either mode.

Top module: `tod_alarm_cmp`

## Requirements
- R1: The minutes alarm byte is at address 3: bit 7 is its mask and bits 6:0 are the BCD minutes. The hours alarm byte is at address 5: bit 7 is its mask and bits 6:0 are the hour byte. The day alarm byte is at address 7: bit 7 is its mask and bits 2:0 are the day. A write takes effect on the next cycle. Address 7 always reads 0 in bits 6:3. Every other address reads 0x00. All three bytes reset to 0x00.
- R2: An evaluation happens only in a cycle with cs_tick = 1, cur_hund = 8'h99 and cur_sec = 8'h00. Nothing fires in any other cycle.
- R3: With all three masks set, every evaluation fires.
- R4: With only the minutes mask clear, an evaluation fires when cur_min equals the minutes field.
- R5: With only the day mask set, an evaluation fires when both minutes and hours match.
- R6: With no mask set, an evaluation fires only when minutes, hours and day all match.
- R7: Any other mask combination ignores each masked field and compares the rest. For example, a set minutes mask and a set day mask fire when the hours match.
- R8: A firing evaluation sets alarm_flag one cycle later. In level mode (pulse_mode = 0) the flag holds until a read or write access to address 3, 5 or 7. An access to any other address leaves it set. If a firing evaluation and a clearing access fall in the same cycle, the flag is set.
- R9: In pulse mode the flag stays high for exactly PULSE_CYC cycles and then drops. An access to an alarm byte ends it early.
- R10: irq_off = 1 holds both interrupt outputs low while the flag still sets.
- R11: route_a = 1 puts the interrupt (flag and not irq_off) on irq_a and keeps irq_b low. route_a = 0 does the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_tick | input | 1 | One-cycle strobe for each hundredths step |
| cur_hund | input | 8 | Running hundredths, BCD |
| cur_sec | input | 8 | Pending seconds, BCD |
| cur_min | input | 7 | Pending minutes, BCD |
| cur_hour | input | 7 | Pending hour byte (format bit, AM/PM or tens, units) |
| cur_day | input | 3 | Pending day of week |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for acc_addr, combinational |
| irq_off | input | 1 | Interrupt suppress |
| pulse_mode | input | 1 | 1 selects pulse mode, 0 selects level mode |
| route_a | input | 1 | Output steering for the interrupt |
| alarm_flag | output | 1 | Read-only alarm flag |
| irq_a | output | 1 | Interrupt output A, active high |
| irq_b | output | 1 | Interrupt output B, active high |

## Verification
The bench builds the block with PULSE_CYC = 6 and the default ADDR_W = 4. With the shorter pulse, the exact pulse length and its early clear can be observed cycle by cycle. A pulse of the default length would take far more cycles than a short run allows. The default address width keeps the alarm bytes at addresses 3, 5 and 7, with decoy addresses beside them to show that those accesses do not clear the flag.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    typedef struct packed {
        logic       m_min;
        logic [6:0] min;
        logic       m_hour;
        logic [6:0] hour;
        logic       m_day;
        logic [2:0] day;
    } alm_cfg_t;

    typedef struct packed {
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] day;
    } tod_t;

    localparam logic [7:0] HUND_LAST = 8'h99;
    localparam logic [7:0] SEC_FIRST = 8'h00;

    function automatic logic fld_ok(input logic masked, input logic equal);
        return masked | equal;
    endfunction

    function automatic logic [7:0] day_view(input logic m, input logic [2:0] d);
        return {m, 4'b0000, d};
    endfunction

endpackage

// File: rtl/tda_regs.sv
module tda_regs
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_MIN  = 3,
    parameter int ADDR_HOUR = 5,
    parameter int ADDR_DAY  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output alm_cfg_t          cfg,
    output logic [7:0]        rdata,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(ADDR_MIN);
    localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(ADDR_HOUR);
    localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(ADDR_DAY);

    alm_cfg_t cfg_q;
    logic     sel_min, sel_hour, sel_day;

    assign sel_min  = (acc_addr == A_MIN);
    assign sel_hour = (acc_addr == A_HOUR);
    assign sel_day  = (acc_addr == A_DAY);
    assign hit      = acc_en & (sel_min | sel_hour | sel_day);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (acc_en && acc_we) begin
            if (sel_min)  {cfg_q.m_min, cfg_q.min}   <= acc_wdata;
            if (sel_hour) {cfg_q.m_hour, cfg_q.hour} <= acc_wdata;
            if (sel_day) begin
                cfg_q.m_day <= acc_wdata[7];
                cfg_q.day   <= acc_wdata[2:0];
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (sel_min)  rdata = {cfg_q.m_min, cfg_q.min};
        if (sel_hour) rdata = {cfg_q.m_hour, cfg_q.hour};
        if (sel_day)  rdata = day_view(cfg_q.m_day, cfg_q.day);
    end

    assign cfg = cfg_q;

    // R1
    wr_day_view_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_we && sel_day) |=> (cfg.m_day == $past(acc_wdata[7]) && cfg.day == $past(acc_wdata[2:0])));
endmodule

// File: rtl/tda_match.sv
module tda_match
    import tod_alarm_pkg::*;
(
    input  alm_cfg_t   cfg,
    input  tod_t       now,
    input  logic       cs_tick,
    input  logic [7:0] cur_hund,
    input  logic [7:0] cur_sec,
    output logic       fire
);
    localparam int NFLD = 3;

    logic [NFLD-1:0] fld_mask;
    logic [NFLD-1:0] fld_eq;
    logic [NFLD-1:0] fld_pass;
    logic            window;

    assign fld_mask = {cfg.m_day, cfg.m_hour, cfg.m_min};
    assign fld_eq   = {(now.day == cfg.day), (now.hour == cfg.hour), (now.min == cfg.min)};

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        assign fld_pass[g] = fld_ok(fld_mask[g], fld_eq[g]);
    end

    assign window = cs_tick & (cur_hund == HUND_LAST) & (cur_sec == SEC_FIRST);
    assign fire   = window & (&fld_pass);
endmodule

// File: rtl/tda_irq.sv
module tda_irq #(
    parameter int PULSE_CYC = 600000
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    input  logic pulse_mode,
    output logic flag
);
    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] PLOAD = CW'(PULSE_CYC - 1);

    logic          flag_q;
    logic [CW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            pcnt   <= '0;
        end else if (fire) begin
            flag_q <= 1'b1;
            pcnt   <= PLOAD;
        end else if (clr) begin
            flag_q <= 1'b0;
            pcnt   <= '0;
        end else if (pulse_mode && flag_q) begin
            if (pcnt == '0) flag_q <= 1'b0;
            else            pcnt   <= pcnt - 1'b1;
        end
    end

    assign flag = flag_q;

    // R8
    set_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(fire));
    // R8
    clr_eff_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !fire) |=> !flag_q);
    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !pulse_mode && !clr) |=> flag_q);
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_MIN  = 3,
    parameter int ADDR_HOUR = 5,
    parameter int ADDR_DAY  = 7,
    parameter int PULSE_CYC = 600000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_tick,
    input  logic [7:0]        cur_hund,
    input  logic [7:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [6:0]        cur_hour,
    input  logic [2:0]        cur_day,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic              irq_off,
    input  logic              pulse_mode,
    input  logic              route_a,
    output logic              alarm_flag,
    output logic              irq_a,
    output logic              irq_b
);
    alm_cfg_t cfg;
    tod_t     now;
    logic     hit, fire, live;

    assign now = '{min: cur_min, hour: cur_hour, day: cur_day};

    tda_regs #(
        .ADDR_W(ADDR_W), .ADDR_MIN(ADDR_MIN), .ADDR_HOUR(ADDR_HOUR), .ADDR_DAY(ADDR_DAY)
    ) regs_i (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .cfg(cfg), .rdata(acc_rdata), .hit(hit)
    );

    tda_match match_i (
        .cfg(cfg), .now(now), .cs_tick(cs_tick), .cur_hund(cur_hund),
        .cur_sec(cur_sec), .fire(fire)
    );

    tda_irq #(.PULSE_CYC(PULSE_CYC)) irq_i (
        .clk(clk), .rst(rst), .fire(fire), .clr(hit), .pulse_mode(pulse_mode), .flag(alarm_flag)
    );

    assign live  = alarm_flag & ~irq_off;
    assign irq_a = live & route_a;
    assign irq_b = live & ~route_a;

    // R2
    eval_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(cs_tick && cur_hund == 8'h99 && cur_sec == 8'h00));
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        irq_off |-> !(irq_a || irq_b));
    // R11
    one_out_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_a, irq_b}));
endmodule

// File: tb/tod_alarm_cmp_tb_top.sv
`timescale 1ns/1ps
module tod_alarm_cmp_tb_top;
    localparam int P = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_tick = 1'b0;
    logic [7:0] cur_hund = 8'h00, cur_sec = 8'h00;
    logic [6:0] cur_min = 7'h00, cur_hour = 7'h00;
    logic [2:0] cur_day = 3'd0;
    logic       acc_en = 1'b0, acc_we = 1'b0;
    logic [3:0] acc_addr = 4'd0;
    logic [7:0] acc_wdata = 8'h00, acc_rdata;
    logic       irq_off = 1'b0, pulse_mode = 1'b0, route_a = 1'b1;
    logic       alarm_flag, irq_a, irq_b;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tod_alarm_cmp #(.PULSE_CYC(P)) dut_i (
        .clk(clk), .rst(rst), .cs_tick(cs_tick), .cur_hund(cur_hund), .cur_sec(cur_sec),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day), .acc_en(acc_en),
        .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq_off(irq_off), .pulse_mode(pulse_mode), .route_a(route_a),
        .alarm_flag(alarm_flag), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] m, input logic [6:0] h, input logic [2:0] d);
        cur_min = m; cur_hour = h; cur_day = d;
    endtask

    task automatic evalw(input logic [7:0] hund, input logic [7:0] sec, input logic tick);
        @(negedge clk);
        cur_hund = hund; cur_sec = sec; cs_tick = tick;
        @(negedge clk);
        cs_tick = 1'b0; cur_hund = 8'h00;
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        rd(4'd3, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R8 reset flag", {7'd0, alarm_flag}, 8'h00);
        chk("R11 reset irqs", {6'd0, irq_a, irq_b}, 8'h00);
        rd(4'd3, d); chk("R1 reset min byte", d, 8'h00);
        rd(4'd7, d); chk("R1 reset day byte", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(4'd3, 8'h59); rd(4'd3, d); chk("R1 min byte", d, 8'h59);
        wr(4'd5, 8'hA3); rd(4'd5, d); chk("R1 hour byte", d, 8'hA3);
        wr(4'd7, 8'hFD); rd(4'd7, d); chk("R1 day bits 6:3 zero", d, 8'h85);
        rd(4'd4, d); chk("R1 other address", d, 8'h00);
    endtask

    task automatic t_window();
        wr(4'd3, 8'h80); wr(4'd5, 8'h80); wr(4'd7, 8'h80);
        set_time(7'h12, 7'h08, 3'd2);
        evalw(8'h98, 8'h00, 1'b1); chk("R2 hund 98", {7'd0, alarm_flag}, 8'h00);
        evalw(8'h99, 8'h00, 1'b0); chk("R2 no tick", {7'd0, alarm_flag}, 8'h00);
        evalw(8'h99, 8'h30, 1'b1); chk("R2 mid minute", {7'd0, alarm_flag}, 8'h00);
        evalw(8'h99, 8'h00, 1'b1); chk("R3 every minute", {7'd0, alarm_flag}, 8'h01);
        clear_flag(); chk("R8 read clears", {7'd0, alarm_flag}, 8'h00);
    endtask

    task automatic t_min();
        wr(4'd3, 8'h25); wr(4'd5, 8'h80); wr(4'd7, 8'h80);
        set_time(7'h24, 7'h11, 3'd1);
        evalw(8'h99, 8'h00, 1'b1); chk("R4 minute miss", {7'd0, alarm_flag}, 8'h00);
        set_time(7'h25, 7'h17, 3'd6);
        evalw(8'h99, 8'h00, 1'b1); chk("R4 minute hit", {7'd0, alarm_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_hm();
        wr(4'd3, 8'h25); wr(4'd5, 8'h13); wr(4'd7, 8'h80);
        set_time(7'h25, 7'h14, 3'd1);
        evalw(8'h99, 8'h00, 1'b1); chk("R5 hour miss", {7'd0, alarm_flag}, 8'h00);
        set_time(7'h25, 7'h13, 3'd5);
        evalw(8'h99, 8'h00, 1'b1); chk("R5 hour minute hit", {7'd0, alarm_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_all();
        wr(4'd3, 8'h25); wr(4'd5, 8'h13); wr(4'd7, 8'h03);
        set_time(7'h25, 7'h13, 3'd4);
        evalw(8'h99, 8'h00, 1'b1); chk("R6 day miss", {7'd0, alarm_flag}, 8'h00);
        set_time(7'h25, 7'h13, 3'd3);
        evalw(8'h99, 8'h00, 1'b1); chk("R6 full hit", {7'd0, alarm_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_odd();
        wr(4'd3, 8'h80); wr(4'd5, 8'h13); wr(4'd7, 8'h80);
        set_time(7'h12, 7'h12, 3'd2);
        evalw(8'h99, 8'h00, 1'b1); chk("R7 hour only miss", {7'd0, alarm_flag}, 8'h00);
        set_time(7'h47, 7'h13, 3'd6);
        evalw(8'h99, 8'h00, 1'b1); chk("R7 hour only hit", {7'd0, alarm_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wr(4'd3, 8'h80); wr(4'd5, 8'h80); wr(4'd7, 8'h80);
        evalw(8'h99, 8'h00, 1'b1);
        rd(4'd4, d); chk("R8 decoy read keeps", {7'd0, alarm_flag}, 8'h01);
        wr(4'd6, 8'h11); chk("R8 decoy write keeps", {7'd0, alarm_flag}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R8 level holds", {7'd0, alarm_flag}, 8'h01);
        wr(4'd7, 8'h80); chk("R8 write clears", {7'd0, alarm_flag}, 8'h00);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = 4'd5;
        cur_hund = 8'h99; cur_sec = 8'h00; cs_tick = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; cs_tick = 1'b0; cur_hund = 8'h00;
        chk("R8 fire beats clear", {7'd0, alarm_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_pulse();
        int hi;
        logic [7:0] d;
        pulse_mode = 1'b1;
        evalw(8'h99, 8'h00, 1'b1);
        hi = 0;
        for (int i = 0; i < P + 3; i++) begin
            if (alarm_flag) hi++;
            @(negedge clk);
        end
        chk("R9 pulse length", 8'(hi), 8'(P));
        evalw(8'h99, 8'h00, 1'b1);
        rd(4'd5, d);
        chk("R9 early clear", {7'd0, alarm_flag}, 8'h00);
        pulse_mode = 1'b0;
    endtask

    task automatic t_off_route();
        irq_off = 1'b1; route_a = 1'b1;
        evalw(8'h99, 8'h00, 1'b1);
        chk("R10 flag sets", {7'd0, alarm_flag}, 8'h01);
        chk("R10 outputs quiet", {6'd0, irq_a, irq_b}, 8'h00);
        irq_off = 1'b0; #1;
        chk("R11 route to a", {6'd0, irq_a, irq_b}, 8'h02);
        route_a = 1'b0; #1;
        chk("R11 route to b", {6'd0, irq_a, irq_b}, 8'h01);
        clear_flag();
        chk("R11 cleared outputs", {6'd0, irq_a, irq_b}, 8'h00);
        route_a = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_window();
        t_min();
        t_hm();
        t_all();
        t_odd();
        t_clear();
        t_pulse();
        t_off_route();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule